// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Engine

This block computes 32-bit integer products and quotients one bit per clock, for a processor core that issues at most one multiply or divide at a time. A single-cycle `start` pulse carries a 2-bit operation code and two operands. The engine stays busy for a fixed number of cycles and then pulses `done`. Its two result words, `hi` and `lo`, can be read independently, and they keep their values until the next operation completes.

One accumulator register and a single 34-bit adder serve every operation. For multiplication the adder adds the multiplicand to the upper half of the accumulator. For division it subtracts the divisor, and a step whose result goes negative restores the old remainder. Signed operations work on magnitudes, and the signs are corrected in a final cycle. The hardware never traps: a division by zero completes like any other operation and returns a fixed pattern.

Top module: `muldiv_unit`

## Requirements
- R1: During and right after reset, `busy` and `done` are 0 and `hi` and `lo` are 0.
- R2: Operation code 2'b01 (unsigned multiply) returns the 64-bit unsigned product, with the upper 32 bits on `hi` and the lower 32 bits on `lo`.
- R3: Operation code 2'b00 (signed multiply) returns the 64-bit two's-complement product of the signed operands, split across `hi` and `lo` in the same way.
- R4: Operation code 2'b11 (unsigned divide) with a nonzero divisor places the quotient `opa / opb` on `lo` and the remainder on `hi`.
- R5: Operation code 2'b10 (signed divide) with a nonzero divisor truncates the quotient toward zero. The remainder takes the sign of the dividend. Dividing the most negative value by -1 returns quotient 0x80000000 and remainder 0.
- R6: A divide of either kind with `opb` = 0 completes normally, with `lo` = 0xFFFFFFFF and `hi` = `opa`.
- R7: `start` is accepted on a rising edge while `busy` is 0. `busy` is 1 from the next cycle until `done` rises, 34 rising edges after the accepting edge. `done` lasts exactly one cycle, and `busy` is 0 whenever `done` is 1.
- R8: A `start` pulse while `busy` is 1 is ignored. It neither restarts nor changes the running operation, and it produces no additional `done`.
- R9: `hi` and `lo` change only on the edge that raises `done`. They hold their values while a later operation is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Upper product half or remainder |
| lo | output | 32 | Lower product half or quotient |

## Verification
On every cycle, the bound checker enforces the handshake timing:
- the fixed 34-edge latency
- the single-cycle `done` and its exclusion with `busy`
- that `start` is ignored while busy
- that `hi` and `lo` stay stable between completions

It also checks the unsigned product and the divide-by-zero pattern against operands captured at acceptance. Only the bench's scenarios can show that the signed results are correct: sign combinations, truncation toward zero, the most-negative-by-minus-one case and pseudo-random operands across all four operation codes, each compared with a behavioural model through the scoreboard.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULT  = 2'b00,
    OP_MULTU = 2'b01,
    OP_DIV   = 2'b10,
    OP_DIVU  = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SETUP = 2'b01,
    ST_RUN   = 2'b10,
    ST_FIX   = 2'b11
  } md_state_e;
endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq import muldiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic load_en,
  output logic step_en,
  output logic fix_en
);
  localparam int CW = $clog2(W);

  md_state_e       state;
  logic [CW-1:0]   cnt;
  logic            last_step;

  assign last_step = (state == ST_RUN) && (cnt == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_SETUP;
        ST_SETUP: begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_step) state <= ST_FIX;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign accept  = start && (state == ST_IDLE);
  assign load_en = (state == ST_SETUP);
  assign step_en = (state == ST_RUN);
  assign fix_en  = (state == ST_FIX);
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc,
  input  logic [W-1:0]   dvsr,
  input  logic           is_div,
  output logic [2*W-1:0] acc_nxt
);
  localparam int AW = W + 2;

  logic [AW-1:0] add_x;
  logic [AW-1:0] add_y;
  logic [AW-1:0] add_s;
  logic          went_neg;
  logic [W-1:0]  part_rem;

  // one shared adder: add for multiply, subtract for divide
  always_comb begin
    if (is_div) begin
      add_x = {1'b0, acc[2*W-1:W-1]};
      add_y = ~{2'b00, dvsr};
    end else begin
      add_x = {2'b00, acc[2*W-1:W]};
      add_y = {2'b00, dvsr};
    end
    add_s = add_x + add_y + AW'(is_div);
  end

  assign went_neg = add_s[AW-1];
  assign part_rem = went_neg ? acc[2*W-2:W-1] : add_s[W-1:0];

  always_comb begin
    if (is_div)
      acc_nxt = {part_rem, acc[W-2:0], ~went_neg};
    else if (acc[0])
      acc_nxt = {add_s[W:0], acc[W-1:1]};
    else
      acc_nxt = {1'b0, acc[2*W-1:1]};
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit import muldiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic sgn);
    return (sgn && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [W-1:0] cond_neg(input logic [W-1:0] x, input logic en);
    return en ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [2*W-1:0] cond_neg2(input logic [2*W-1:0] x, input logic en);
    return en ? (~x + 1'b1) : x;
  endfunction

  logic           accept, load_en, step_en, fix_en;
  md_op_e         op_q;
  logic [W-1:0]   a_q, b_q;
  logic [2*W-1:0] acc, acc_nxt;
  logic [W-1:0]   dvsr;
  logic           neg_main, neg_rem, div_zero;
  logic           is_div, is_signed;

  assign is_div    = op_q[1];
  assign is_signed = ~op_q[0];

  muldiv_seq #(.W(W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .accept  (accept),
    .load_en (load_en),
    .step_en (step_en),
    .fix_en  (fix_en)
  );

  muldiv_step #(.W(W)) i_step (
    .acc     (acc),
    .dvsr    (dvsr),
    .is_div  (is_div),
    .acc_nxt (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_MULT;
      a_q      <= '0;
      b_q      <= '0;
      acc      <= '0;
      dvsr     <= '0;
      neg_main <= 1'b0;
      neg_rem  <= 1'b0;
      div_zero <= 1'b0;
      hi       <= '0;
      lo       <= '0;
      done     <= 1'b0;
    end else begin
      done <= fix_en;
      if (accept) begin
        op_q <= md_op_e'(op);
        a_q  <= opa;
        b_q  <= opb;
      end
      if (load_en) begin
        acc      <= {{W{1'b0}}, magnitude(a_q, is_signed)};
        dvsr     <= magnitude(b_q, is_signed);
        neg_main <= is_signed && (a_q[W-1] ^ b_q[W-1]);
        neg_rem  <= is_signed && a_q[W-1];
        div_zero <= is_div && (b_q == '0);
      end
      if (step_en) acc <= acc_nxt;
      if (fix_en) begin
        if (!is_div) begin
          {hi, lo} <= cond_neg2(acc, neg_main);
        end else if (div_zero) begin
          hi <= a_q;
          lo <= '1;
        end else begin
          hi <= cond_neg(acc[2*W-1:W], neg_rem);
          lo <= cond_neg(acc[W-1:0], neg_main);
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk import muldiv_pkg::*; #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo,
  input logic         accept
);
  localparam int LAT = W + 2;

  logic [15:0]  wait_cnt;
  logic [1:0]   cap_op;
  logic [W-1:0] cap_a, cap_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      cap_op   <= '0;
      cap_a    <= '0;
      cap_b    <= '0;
    end else if (accept) begin
      wait_cnt <= '0;
      cap_op   <= op;
      cap_a    <= opa;
      cap_b    <= opb;
    end else if (busy) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy); // R7
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> wait_cnt == 16'(LAT)); // R7
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> wait_cnt == $past(wait_cnt) + 16'd1); // R8
  AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi) && $stable(lo))); // R9
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op[1] && cap_b == '0) |-> (lo == '1 && hi == cap_a)); // R6
  AST_MULTU_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == OP_MULTU) |-> {hi, lo} == ({{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b})); // R2
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .op     (op),
  .opa    (opa),
  .opb    (opb),
  .busy   (busy),
  .done   (done),
  .hi     (hi),
  .lo     (lo),
  .accept (accept)
);

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int n_done = 0;

  typedef struct {
    logic [63:0] exp;
    int          cyc;
    string       req;
  } item_t;
  item_t sbq[$];
  item_t it;

  muldiv_unit i_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference, result as {hi, lo}
  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      2'b00: return 64'(sa * sb);
      2'b01: return {32'b0, a} * {32'b0, b};
      2'b10: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input string req);
    item_t x;
    while (busy) @(negedge clk);
    op = o; opa = a; opb = b; start = 1'b1;
    x.exp = model(o, a, b);
    x.cyc = cyc;
    x.req = req;
    sbq.push_back(x);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0 || busy) @(negedge clk);
  endtask

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (sbq.size() == 0) begin
        chk(1'b0, "R8", "unexpected done", {hi, lo}, 64'd0);
      end else begin
        it = sbq.pop_front();
        chk({hi, lo} == it.exp, it.req, "hi:lo", {hi, lo}, it.exp);
        chk((cyc - it.cyc) == 35, "R7", "latency", 64'(cyc - it.cyc), 64'd35);
        chk(!busy, "R7", "busy with done", 64'(busy), 64'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] x;
    logic [31:0] a, b;
    logic [31:0] h0, l0;
    int          d0;
    x = 32'h1234_5679;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 64'd0);
    chk(hi == 0 && lo == 0, "R1", "hi:lo after reset", {hi, lo}, 64'd0);

    issue(2'b01, 32'd7, 32'd6, "R2");
    issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    issue(2'b00, 32'hFFFF_FFF9, 32'd6, "R3");
    issue(2'b00, 32'h8000_0000, 32'h8000_0000, "R3");
    issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    issue(2'b00, 32'd12345, 32'hFFFF_0000, "R3");
    issue(2'b11, 32'd100, 32'd7, "R4");
    issue(2'b11, 32'hFFFF_FFFF, 32'd1, "R4");
    issue(2'b11, 32'd5, 32'hFFFF_FFF0, "R4");
    issue(2'b10, 32'hFFFF_FFF9, 32'd2, "R5");
    issue(2'b10, 32'd7, 32'hFFFF_FFFE, "R5");
    issue(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5");
    issue(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R5");
    issue(2'b11, 32'hDEAD_BEEF, 32'd0, "R6");
    issue(2'b10, 32'hF000_0001, 32'd0, "R6");
    issue(2'b10, 32'd0, 32'd0, "R6");

    for (int i = 0; i < 24; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      a = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      b = (i % 4 >= 2) ? (x >> x[4:0]) : x;
      case (i % 4)
        0: issue(2'b00, a, b, "R3");
        1: issue(2'b01, a, b, "R2");
        2: issue(2'b10, a, b, "R5");
        default: issue(2'b11, a, b, "R4");
      endcase
    end
    drain();

    // R8: a second start during a running operation is ignored
    d0 = n_done;
    issue(2'b11, 32'd1000, 32'd3, "R8");
    repeat (4) @(negedge clk);
    op = 2'b01; opa = 32'd9; opb = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (40) @(negedge clk);
    chk(n_done == d0 + 1, "R8", "done count", 64'(n_done - d0), 64'd1);
    chk(hi == 32'd1 && lo == 32'd333, "R8", "result kept", {hi, lo}, {32'd1, 32'd333});

    // R9: results hold while the next operation runs
    h0 = hi; l0 = lo;
    issue(2'b00, 32'd3, 32'd4, "R3");
    repeat (20) @(negedge clk);
    chk(busy, "R7", "busy mid-operation", 64'(busy), 64'd1);
    chk(hi == h0 && lo == l0, "R9", "hold while busy", {hi, lo}, {h0, l0});
    drain();
    repeat (5) @(negedge clk);
    chk(hi == 32'd0 && lo == 32'd12, "R9", "hold after done", {hi, lo}, {32'd0, 32'd12});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule